// File: doc/BRIEF.md
# One-Hot Parallel Multiplexer with Fallback Word

This block is a purely combinational selector. It takes one fallback data word, a packed bus that holds one candidate word per select line, and a select vector that is meant to be one-hot. With no select line active the fallback word goes to the output. With exactly one line active, the candidate word for that line goes to the output. Candidate 0 sits in the least significant bits of the packed bus.

The case where more than one select line is active depends on an elaboration-time policy parameter. In merge policy the output is the bitwise OR of every selected candidate. This keeps the result deterministic, but callers should not rely on it. In fallback policy the output returns to the fallback word. In both policies a separate flag reports that the select was not one-hot. Illegal sizes (a word width or select width below one) stop elaboration.

Top module: `onehot_fallback_mux`

## Requirements
- R1: When every bit of `sel_i` is 0, `y_o` equals `dflt_i`.
- R2: When only bit n of `sel_i` is set, `y_o` equals `cand_i[n*WORD_W +: WORD_W]`, so candidate 0 occupies the least significant `WORD_W` bits.
- R3: With `POLICY` set to `MULTI_DEFAULT`, `y_o` equals `dflt_i` whenever two or more bits of `sel_i` are set.
- R4: With `POLICY` set to `MULTI_MERGE`, `y_o` equals the bitwise OR of all selected candidate words whenever two or more bits of `sel_i` are set.
- R5: `multi_o` is 1 exactly when two or more bits of `sel_i` are set, under either policy, and is 0 otherwise.
- R6: The block has no clock or state: `y_o` and `multi_o` follow a change on any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dflt_i | input | WORD_W | Fallback word, used when no line (or, under fallback policy, several lines) is selected |
| cand_i | input | WORD_W*LINES | Packed candidate words, candidate 0 in the low bits |
| sel_i | input | LINES | Select vector, one bit per candidate |
| y_o | output | WORD_W | Selected word |
| multi_o | output | 1 | High when the select has two or more bits set |

## Verification
The hard cases are the patterns with several select lines active. A correct design never produces them on purpose, and every policy difference lies there. The bench builds both policies side by side with four select lines and drives all sixteen select patterns against several data sets. The candidate words use disjoint and overlapping bit patterns, so an OR-merge can be told apart from a single pick and from the fallback word. Directed steps then cover the top and bottom candidate slices and show that the outputs move with no clock edge between input changes.

// File: rtl/onehot_mux_pkg.sv
package onehot_mux_pkg;

   typedef enum logic [0:0] {
      MULTI_MERGE   = 1'b0,
      MULTI_DEFAULT = 1'b1
   } multi_policy_e;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_ONE   = 2'd1,
      SEL_MULTI = 2'd2
   } sel_class_e;

endpackage

// File: rtl/sel_classifier.sv
module sel_classifier #(
   parameter int LINES = 4
) (
   input  logic [LINES-1:0]          sel_i,
   output onehot_mux_pkg::sel_class_e class_o
);
   import onehot_mux_pkg::*;

   logic seen_any;
   logic seen_two;

   // running scan: a second hit after any earlier hit marks multi-hot
   always_comb begin
      seen_any = 1'b0;
      seen_two = 1'b0;
      for (int k = 0; k < LINES; k++) begin
         seen_two = seen_two | (seen_any & sel_i[k]);
         seen_any = seen_any | sel_i[k];
      end
   end

   always_comb begin
      if (seen_two)      class_o = SEL_MULTI;
      else if (seen_any) class_o = SEL_ONE;
      else               class_o = SEL_NONE;
   end

   // R5
   always_comb begin
      multi_count_chk: assert (($countones(sel_i) > 1) == (class_o == SEL_MULTI))
         else $error("classifier disagrees with popcount");
   end

endmodule

// File: rtl/slice_or_mux.sv
module slice_or_mux #(
   parameter int WORD_W = 8,
   parameter int LINES  = 4
) (
   input  logic [WORD_W*LINES-1:0] cand_i,
   input  logic [LINES-1:0]        sel_i,
   output logic [WORD_W-1:0]       merged_o
);
   logic [WORD_W-1:0] gated [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_gate
      assign gated[g] = cand_i[g*WORD_W +: WORD_W] & {WORD_W{sel_i[g]}};
   end

   always_comb begin
      merged_o = '0;
      for (int k = 0; k < LINES; k++) begin
         merged_o = merged_o | gated[k];
      end
   end

   // R2
   always_comb begin
      for (int k = 0; k < LINES; k++) begin
         if (sel_i == (LINES'(1) << k)) begin
            single_slice_chk: assert (merged_o == cand_i[k*WORD_W +: WORD_W])
               else $error("lone select did not pass its slice");
         end
      end
   end

endmodule

// File: rtl/onehot_fallback_mux.sv
module onehot_fallback_mux #(
   parameter int WORD_W = 8,
   parameter int LINES  = 4,
   parameter onehot_mux_pkg::multi_policy_e POLICY = onehot_mux_pkg::MULTI_DEFAULT
) (
   input  logic [WORD_W-1:0]       dflt_i,
   input  logic [WORD_W*LINES-1:0] cand_i,
   input  logic [LINES-1:0]        sel_i,
   output logic [WORD_W-1:0]       y_o,
   output logic                    multi_o
);
   import onehot_mux_pkg::*;

   if (WORD_W < 1) begin : g_bad_word
      $error("WORD_W must be at least 1");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("LINES must be at least 1");
   end

   sel_class_e        sel_class;
   logic [WORD_W-1:0] merged;

   sel_classifier #(.LINES(LINES)) u_class (
      .sel_i   (sel_i),
      .class_o (sel_class)
   );

   slice_or_mux #(.WORD_W(WORD_W), .LINES(LINES)) u_merge (
      .cand_i   (cand_i),
      .sel_i    (sel_i),
      .merged_o (merged)
   );

   assign multi_o = (sel_class == SEL_MULTI);

   if (POLICY == MULTI_DEFAULT) begin : g_safe
      always_comb y_o = (sel_class == SEL_ONE) ? merged : dflt_i;

      // R3
      always_comb begin
         if (multi_o) begin
            safe_fallback_chk: assert (y_o == dflt_i)
               else $error("multi-hot select did not return the fallback word");
         end
      end
   end else begin : g_merge
      always_comb y_o = (sel_class == SEL_NONE) ? dflt_i : merged;

      // R4
      always_comb begin
         if (multi_o) begin
            merge_cover_chk: assert ((y_o & merged) == merged)
               else $error("merged output lost a selected bit");
         end
      end
   end

   // R1
   always_comb begin
      if (sel_i == '0) begin
         idle_default_chk: assert (y_o == dflt_i && !multi_o)
            else $error("empty select did not give the fallback word");
      end
   end

endmodule

// File: tb/onehot_fallback_mux_test.sv
module onehot_fallback_mux_test;
   import onehot_mux_pkg::*;

   localparam int W = 8;
   localparam int L = 4;
   localparam time HALF = 5ns;

   // each entry: {expected multi flag, select pattern}
   localparam logic [4:0] VEC [16] = '{
      5'b0_0000, 5'b0_0001, 5'b0_0010, 5'b1_0011,
      5'b0_0100, 5'b1_0101, 5'b1_0110, 5'b1_0111,
      5'b0_1000, 5'b1_1001, 5'b1_1010, 5'b1_1011,
      5'b1_1100, 5'b1_1101, 5'b1_1110, 5'b1_1111
   };

   logic clk = 1'b0;
   always #HALF clk = ~clk;

   logic [W-1:0]   dflt;
   logic [W*L-1:0] cand;
   logic [L-1:0]   sel;
   logic [W-1:0]   y_safe, y_merge;
   logic           m_safe, m_merge;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   onehot_fallback_mux #(.WORD_W(W), .LINES(L), .POLICY(MULTI_DEFAULT)) uut (
      .dflt_i(dflt), .cand_i(cand), .sel_i(sel), .y_o(y_safe), .multi_o(m_safe)
   );

   onehot_fallback_mux #(.WORD_W(W), .LINES(L), .POLICY(MULTI_MERGE)) uut_merge (
      .dflt_i(dflt), .cand_i(cand), .sel_i(sel), .y_o(y_merge), .multi_o(m_merge)
   );

   function automatic logic [W-1:0] expect_y(bit safe, logic [W-1:0] a,
                                             logic [W*L-1:0] b, logic [L-1:0] s);
      int n = 0;
      logic [W-1:0] acc = '0;
      for (int k = 0; k < L; k++) begin
         if (s[k]) begin
            n++;
            acc |= b[k*W +: W];
         end
      end
      if (n == 0) return a;
      if (n == 1) return acc;
      return safe ? a : acc;
   endfunction

   task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s sel=%b got=%h expected=%h", req, sel, got, exp);
      end
   endtask

   task automatic check_bit(string req, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s sel=%b got=%b expected=%b", req, sel, got, exp);
      end
   endtask

   function automatic string tag_for(logic [L-1:0] s, bit safe);
      int n = $countones(s);
      if (n == 0) return "R1";
      if (n == 1) return "R2";
      return safe ? "R3" : "R4";
   endfunction

   initial begin
      dflt = '0; cand = '0; sel = '0;
      @(negedge clk);
      // R1 idle state
      check("R1", y_safe, '0);
      check_bit("R5", m_safe, 1'b0);

      for (int d = 0; d < 3; d++) begin
         case (d)
            0: begin dflt = 8'hA5; cand = 32'h08_04_02_01; end
            1: begin dflt = 8'h3C; cand = 32'hF0_0F_CC_33; end
            default: begin dflt = 8'h00; cand = 32'h81_42_24_18; end
         endcase
         for (int v = 0; v < 16; v++) begin
            sel = VEC[v][L-1:0];
            @(negedge clk);
            check(tag_for(sel, 1'b1), y_safe,  expect_y(1'b1, dflt, cand, sel));
            check(tag_for(sel, 1'b0), y_merge, expect_y(1'b0, dflt, cand, sel));
            check_bit("R5", m_safe,  VEC[v][4]);
            check_bit("R5", m_merge, VEC[v][4]);
         end
      end

      // R2 boundary slices: lowest and highest candidate
      dflt = 8'h11; cand = 32'hDE_AD_BE_EF;
      sel = 4'b0001; @(negedge clk);
      check("R2", y_safe, 8'hEF);
      sel = 4'b1000; @(negedge clk);
      check("R2", y_merge, 8'hDE);

      // R6 outputs follow inputs with no clock edge between changes
      @(posedge clk); #1;
      sel = 4'b0100; #1;
      check("R6", y_safe, 8'hAD);
      cand[23:16] = 8'h5A; #1;
      check("R6", y_merge, 8'h5A);
      sel = 4'b0110; #1;
      check("R6", y_safe, 8'h11);
      check_bit("R6", m_merge, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule